// File: doc/BRIEF.md
# Packed Lane Shift, Rotate and Halfword Permute Unit

This block is one stage of a SIMD datapath. It takes a 64-bit operand and applies one of four shift-type operations to every lane at once: logical left, logical right, arithmetic right or rotate right. The lane width is 16, 32 or 64 bits. A fifth operation rearranges the four halfwords of the operand under an 8-bit selector. Lanes never exchange bits; each lane behaves as an independent register of its own width.

The block also produces a 32-bit packed status word. For every lane of the active width it holds a sign flag (the lane's top bit) and a zero flag (the lane is all zeros). Both the result and the status are registered, so they appear one clock after the request. The surrounding pipeline supplies a request strobe, operation code, lane-width code, shift amount and permute selector.

Top module: `psrs_unit`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high, and `result`/`flags` then hold that request's values. A synchronous active-high `rst` clears `out_valid`, `result` and `flags` to zero, even while `in_valid` is high.
- R2: Operation code 0 is a logical left shift of each lane by `amount`. Bits shifted past the top of a lane are lost, and zeros enter at the bottom. An amount at or above the lane width gives zero.
- R3: Operation code 1 is a logical right shift of each lane. Zeros enter at the top of the lane, and an amount at or above the lane width gives zero.
- R4: Operation code 2 is an arithmetic right shift of each lane. Copies of the lane's own top bit fill from the top. An amount at or above the lane width gives every bit equal to that top bit.
- R5: Operation code 3 rotates each lane right by `amount` modulo the lane width. Bits leave the bottom and re-enter the top of the same lane, and an effective rotation of zero returns the lane unchanged.
- R6: `lane_sel` 0 selects 16-bit lanes and 1 selects 32-bit lanes. Both 2 and 3 select a single 64-bit lane.
- R7: Operation code 4 is a halfword permute. Result halfword j (bits 16j+15..16j) is the operand halfword whose index is `perm_sel[2j+1:2j]`. `amount` and `lane_sel` do not affect this operation.
- R8: With 16-bit lanes, the sign flag of lane k is at `flags` bit 8k+7 and the zero flag at bit 8k+6. All other flag bits are 0.
- R9: With 32-bit lanes, the sign flag of lane k is at bit 16k+15 and the zero flag at bit 16k+14. All other flag bits are 0.
- R10: With the 64-bit lane, the sign flag is at bit 31 and the zero flag at bit 30. All other flag bits are 0.
- R11: The halfword permute always reports its flags in the 16-bit layout of R8, whatever `lane_sel` is.
- R12: Operation codes 5, 6 and 7 give a zero result and all-zero flags.
- R13: All 8 bits of `amount` count. For shifts, a value such as 0x41 on a 64-bit lane, or 0x80 on any lane, is oversize under R2–R4. For rotates only the value modulo the lane width matters, so 0x11 on 16-bit lanes rotates by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | Operation code (R2–R5, R7, R12) |
| lane_sel | input | 2 | Lane width code (R6) |
| operand | input | 64 | Source data |
| amount | input | 8 | Shift or rotate amount |
| perm_sel | input | 8 | Halfword permute selectors, 2 bits per destination halfword |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 64 | Registered result |
| flags | output | 32 | Registered packed sign/zero status |

## Verification
Operands with set bits next to every lane boundary, shifted by one bit, show whether bits leak between lanes. The same operand is shifted at each lane width, which separates the 16-, 32- and 64-bit lane paths. Amounts just below the lane width, equal to it, and with only high bits set (0x41, 0x80, 0x11) separate the oversize rule from a modulo wrap, and rotate from the shifts. Permutes with the identity, reversed and broadcast selectors, and operands chosen to give zero and negative lanes, confirm that each flag bit lands in its own slot for every layout.

// File: rtl/psrs_pkg.sv
package psrs_pkg;

    localparam int DATA_W  = 64;
    localparam int AMT_W   = 8;
    localparam int HALF_W  = 16;
    localparam int FLAG_W  = 32;
    localparam int N_SIZES = 3;

    typedef enum logic [2:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_ASR  = 3'd2,
        OP_ROR  = 3'd3,
        OP_PERM = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        LS_HALF  = 2'd0,
        LS_WORD  = 2'd1,
        LS_DWORD = 2'd2,
        LS_ALT   = 2'd3
    } lsize_e;

    // Map the lane width code onto an index into the per-width banks.
    function automatic logic [1:0] size_index(input logic [1:0] code);
        case (code)
            LS_HALF: return 2'd0;
            LS_WORD: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/psrs_lane_bank.sv
module psrs_lane_bank #(
    parameter int DATA_W = psrs_pkg::DATA_W,
    parameter int LANE_W = psrs_pkg::HALF_W,
    parameter int AMT_W  = psrs_pkg::AMT_W
) (
    input  logic [DATA_W-1:0] operand,
    input  logic [AMT_W-1:0]  amount,
    output logic [DATA_W-1:0] shl_o,
    output logic [DATA_W-1:0] shr_o,
    output logic [DATA_W-1:0] asr_o,
    output logic [DATA_W-1:0] ror_o
);
    localparam int LANES = DATA_W / LANE_W;
    localparam int SH_W  = $clog2(LANE_W);

    logic            oversize;
    logic [SH_W-1:0] sh;

    // The full amount decides oversize; the low bits are the in-lane distance.
    assign oversize = (int'(amount) >= LANE_W);
    assign sh       = amount[SH_W-1:0];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0]   src;
        logic [2*LANE_W-1:0] twin;
        logic [LANE_W-1:0]   sra_v;

        assign src   = operand[k*LANE_W +: LANE_W];
        assign twin  = {src, src} >> sh;
        assign sra_v = $signed(src) >>> sh;

        assign shl_o[k*LANE_W +: LANE_W] = oversize ? '0 : (src << sh);
        assign shr_o[k*LANE_W +: LANE_W] = oversize ? '0 : (src >> sh);
        assign asr_o[k*LANE_W +: LANE_W] = oversize ? {LANE_W{src[LANE_W-1]}} : sra_v;
        assign ror_o[k*LANE_W +: LANE_W] = twin[LANE_W-1:0];
    end

endmodule

// File: rtl/psrs_permute.sv
module psrs_permute #(
    parameter int DATA_W = psrs_pkg::DATA_W,
    parameter int HALF_W = psrs_pkg::HALF_W
) (
    input  logic [DATA_W-1:0]        operand,
    input  logic [2*(DATA_W/HALF_W)-1:0] perm_sel,
    output logic [DATA_W-1:0]        permuted
);
    localparam int N_HALF = DATA_W / HALF_W;
    localparam int SEL_W  = $clog2(N_HALF);

    for (genvar j = 0; j < N_HALF; j++) begin : g_dst
        logic [SEL_W-1:0] pick;
        assign pick = perm_sel[j*SEL_W +: SEL_W];
        assign permuted[j*HALF_W +: HALF_W] = operand[pick*HALF_W +: HALF_W];
    end

endmodule

// File: rtl/psrs_flag_gen.sv
module psrs_flag_gen #(
    parameter int DATA_W  = psrs_pkg::DATA_W,
    parameter int HALF_W  = psrs_pkg::HALF_W,
    parameter int FLAG_W  = psrs_pkg::FLAG_W,
    parameter int N_SIZES = psrs_pkg::N_SIZES
) (
    input  logic [DATA_W-1:0] value,
    input  logic [1:0]        mode_idx,
    input  logic              enable,
    output logic [FLAG_W-1:0] flags
);
    logic [FLAG_W-1:0] per_size [N_SIZES];

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int LW    = HALF_W << g;
        localparam int LANES = DATA_W / LW;
        localparam int SLOT  = FLAG_W / LANES;

        logic [FLAG_W-1:0] packed_f;

        // Each lane owns a SLOT-wide field: sign at the top, zero just below.
        always_comb begin
            packed_f = '0;
            for (int k = 0; k < LANES; k++) begin
                packed_f[SLOT*k + SLOT - 1] = value[LW*k + LW - 1];
                packed_f[SLOT*k + SLOT - 2] = (value[LW*k +: LW] == '0);
            end
        end

        assign per_size[g] = packed_f;
    end

    assign flags = (enable && (int'(mode_idx) < N_SIZES)) ? per_size[mode_idx] : '0;

endmodule

// File: rtl/psrs_unit.sv
module psrs_unit #(
    parameter int DATA_W = psrs_pkg::DATA_W,
    parameter int AMT_W  = psrs_pkg::AMT_W,
    parameter int HALF_W = psrs_pkg::HALF_W,
    parameter int FLAG_W = psrs_pkg::FLAG_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        in_valid,
    input  logic [2:0]                  op,
    input  logic [1:0]                  lane_sel,
    input  logic [DATA_W-1:0]           operand,
    input  logic [AMT_W-1:0]            amount,
    input  logic [2*(DATA_W/HALF_W)-1:0] perm_sel,
    output logic                        out_valid,
    output logic [DATA_W-1:0]           result,
    output logic [FLAG_W-1:0]           flags
);
    import psrs_pkg::*;

    localparam int NS = psrs_pkg::N_SIZES;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic [FLAG_W-1:0] flags;
    } res_t;

    logic [DATA_W-1:0] shl_v [NS];
    logic [DATA_W-1:0] shr_v [NS];
    logic [DATA_W-1:0] asr_v [NS];
    logic [DATA_W-1:0] ror_v [NS];
    logic [DATA_W-1:0] perm_v;

    logic [1:0]        size_idx;
    logic [1:0]        flag_mode;
    logic              flag_en;
    logic [DATA_W-1:0] nxt_value;
    logic [FLAG_W-1:0] nxt_flags;
    res_t              res_d;
    res_t              res_q;
    logic              vld_q;

    assign size_idx = size_index(lane_sel);

    // One shifter bank per supported lane width.
    for (genvar g = 0; g < NS; g++) begin : g_bank
        psrs_lane_bank #(
            .DATA_W(DATA_W),
            .LANE_W(HALF_W << g),
            .AMT_W (AMT_W)
        ) u_bank (
            .operand(operand),
            .amount (amount),
            .shl_o  (shl_v[g]),
            .shr_o  (shr_v[g]),
            .asr_o  (asr_v[g]),
            .ror_o  (ror_v[g])
        );
    end

    psrs_permute #(
        .DATA_W(DATA_W),
        .HALF_W(HALF_W)
    ) u_perm (
        .operand (operand),
        .perm_sel(perm_sel),
        .permuted(perm_v)
    );

    always_comb begin
        nxt_value = '0;
        flag_mode = size_idx;
        flag_en   = 1'b1;
        case (op)
            OP_SHL:  nxt_value = shl_v[size_idx];
            OP_SHR:  nxt_value = shr_v[size_idx];
            OP_ASR:  nxt_value = asr_v[size_idx];
            OP_ROR:  nxt_value = ror_v[size_idx];
            OP_PERM: begin
                nxt_value = perm_v;
                flag_mode = 2'd0;
            end
            default: flag_en = 1'b0;
        endcase
    end

    psrs_flag_gen #(
        .DATA_W (DATA_W),
        .HALF_W (HALF_W),
        .FLAG_W (FLAG_W),
        .N_SIZES(NS)
    ) u_flags (
        .value   (nxt_value),
        .mode_idx(flag_mode),
        .enable  (flag_en),
        .flags   (nxt_flags)
    );

    assign res_d.value = nxt_value;
    assign res_d.flags = nxt_flags;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) begin
                res_q <= res_d;
            end
        end
    end

    assign out_valid = vld_q;
    assign result    = res_q.value;
    assign flags     = res_q.flags;

endmodule

// File: rtl/psrs_unit_chk.sv
module psrs_unit_chk #(
    parameter int DATA_W = psrs_pkg::DATA_W,
    parameter int AMT_W  = psrs_pkg::AMT_W,
    parameter int HALF_W = psrs_pkg::HALF_W,
    parameter int FLAG_W = psrs_pkg::FLAG_W
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        in_valid,
    input logic [2:0]                  op,
    input logic [1:0]                  lane_sel,
    input logic [DATA_W-1:0]           operand,
    input logic [AMT_W-1:0]            amount,
    input logic [2*(DATA_W/HALF_W)-1:0] perm_sel,
    input logic                        out_valid,
    input logic [DATA_W-1:0]           result,
    input logic [FLAG_W-1:0]           flags
);
    localparam int N_HALF = DATA_W / HALF_W;
    localparam int HSLOT  = FLAG_W / N_HALF;
    localparam logic [2*(DATA_W/HALF_W)-1:0] IDENT = 8'hE4;

    logic half_layout;
    logic big_lane;

    assign half_layout = (op == 3'd4) || (op < 3'd4 && lane_sel == 2'd0);
    assign big_lane    = (lane_sel == 2'd0) ? (int'(amount) >= HALF_W)
                       : (lane_sel == 2'd1) ? (int'(amount) >= 2*HALF_W)
                       : (int'(amount) >= 4*HALF_W);

    // R1: reset clears the registered outputs.
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0 && flags == '0));

    // R1: one-cycle strobe latency.
    assert_valid_latency_R1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);

    // R2: oversize left shift empties every lane.
    assert_shl_oversize_R2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd0 && big_lane) |=> (result == '0));

    // R5: zero rotation is the identity.
    assert_ror_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd3 && amount == '0) |=> (result == $past(operand)));

    // R7: identity selector pattern returns the operand.
    assert_perm_identity_R7: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 3'd4 && perm_sel == IDENT) |=> (result == $past(operand)));

    // R12: unused operation codes give zeros.
    assert_unused_op_R12: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op > 3'd4) |=> (result == '0 && flags == '0));

    for (genvar k = 0; k < N_HALF; k++) begin : g_half
        // R8 and R11: halfword flag layout agrees with the registered result.
        assert_half_flags_R8: assert property (@(posedge clk) disable iff (rst)
            (in_valid && half_layout) |=>
                (flags[HSLOT*k + HSLOT - 1] == result[HALF_W*k + HALF_W - 1]) &&
                (flags[HSLOT*k + HSLOT - 2] == (result[HALF_W*k +: HALF_W] == '0)) &&
                (flags[HSLOT*k +: HSLOT-2] == '0));

        // R4: oversize arithmetic shift on halfword lanes replicates the sign.
        assert_asr_oversize_R4: assert property (@(posedge clk) disable iff (rst)
            (in_valid && op == 3'd2 && lane_sel == 2'd0 && big_lane) |=>
                (result[HALF_W*k +: HALF_W] ==
                 {HALF_W{$past(operand[HALF_W*k + HALF_W - 1])}}));
    end

endmodule

bind psrs_unit psrs_unit_chk #(
    .DATA_W(DATA_W),
    .AMT_W (AMT_W),
    .HALF_W(HALF_W),
    .FLAG_W(FLAG_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .op       (op),
    .lane_sel (lane_sel),
    .operand  (operand),
    .amount   (amount),
    .perm_sel (perm_sel),
    .out_valid(out_valid),
    .result   (result),
    .flags    (flags)
);

// File: tb/psrs_unit_tb_top.sv
module psrs_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [1:0]  lane_sel = 2'd0;
    logic [63:0] operand = 64'd0;
    logic [7:0]  amount = 8'd0;
    logic [7:0]  perm_sel = 8'd0;
    logic        out_valid;
    logic [63:0] result;
    logic [31:0] flags;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [63:0] exp_r [$];
    logic [31:0] exp_f [$];
    string       exp_tag [$];

    always #2 clk = ~clk;

    psrs_unit dut_i (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .op       (op),
        .lane_sel (lane_sel),
        .operand  (operand),
        .amount   (amount),
        .perm_sel (perm_sel),
        .out_valid(out_valid),
        .result   (result),
        .flags    (flags)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    // Bit-level reference written from the requirements.
    function automatic logic [95:0] model(input int opc, input int sz, input logic [63:0] x,
                                          input int amt, input logic [7:0] sel);
        logic [63:0] r;
        logic [31:0] f;
        int w;
        int fw;
        int slot;
        int src;
        bit zero;
        r = '0;
        f = '0;
        w = (sz == 0) ? 16 : (sz == 1) ? 32 : 64;
        fw = w;
        if (opc == 4) begin
            fw = 16;
            for (int j = 0; j < 4; j++) r[16*j +: 16] = x[16*sel[2*j +: 2] +: 16];
        end else if (opc < 4) begin
            for (int base = 0; base < 64; base += w) begin
                for (int i = 0; i < w; i++) begin
                    case (opc)
                        0: begin src = i - amt; r[base+i] = (src >= 0) ? x[base+src] : 1'b0; end
                        1: begin src = i + amt; r[base+i] = (src < w) ? x[base+src] : 1'b0; end
                        2: begin src = i + amt; r[base+i] = (src < w) ? x[base+src] : x[base+w-1]; end
                        default: begin src = (i + amt) % w; r[base+i] = x[base+src]; end
                    endcase
                end
            end
        end
        if (opc <= 4) begin
            slot = 32 / (64 / fw);
            for (int k = 0; k < 64 / fw; k++) begin
                zero = 1'b1;
                for (int b = 0; b < fw; b++) if (r[fw*k+b]) zero = 1'b0;
                f[slot*k + slot - 1] = r[fw*k + fw - 1];
                f[slot*k + slot - 2] = zero;
            end
        end
        return {f, r};
    endfunction

    task automatic send(input int opc, input int sz, input logic [63:0] x,
                        input int amt, input logic [7:0] sel, input string tag);
        logic [95:0] e;
        @(negedge clk);
        in_valid = 1'b1;
        op       = 3'(opc);
        lane_sel = 2'(sz);
        operand  = x;
        amount   = 8'(amt);
        perm_sel = sel;
        e = model(opc, sz, x, amt, sel);
        exp_r.push_back(e[63:0]);
        exp_f.push_back(e[95:64]);
        exp_tag.push_back(tag);
    endtask

    // Monitor: pop one expectation per result strobe.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_r.size() == 0) begin
                check(1'b0, "R1", "unexpected out_valid", 64'd1, 64'd0);
            end else begin
                logic [63:0] er;
                logic [31:0] ef;
                string       et;
                er = exp_r.pop_front();
                ef = exp_f.pop_front();
                et = exp_tag.pop_front();
                check(result == er, et, "result", result, er);
                check(flags == ef, et, "flags", {32'd0, flags}, {32'd0, ef});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset holds outputs at zero even with a request pending.
        in_valid = 1'b1;
        operand  = 64'hFFFF_FFFF_FFFF_FFFF;
        op       = 3'd4;
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid in reset", {63'd0, out_valid}, 64'd0);
        check(result == '0, "R1", "result in reset", result, 64'd0);
        check(flags == '0, "R1", "flags in reset", {32'd0, flags}, 64'd0);
        rst      = 1'b0;
        in_valid = 1'b0;

        // R2: logical left, no crossing, oversize.
        send(0, 0, 64'h8001_4003_0F0F_FFFF, 1, 8'h00, "R2");
        send(0, 0, 64'h8001_4003_0F0F_FFFF, 16, 8'h00, "R2");
        send(0, 1, 64'h8000_0001_F000_000F, 4, 8'h00, "R2");
        send(0, 2, 64'h0000_0000_0000_0003, 63, 8'h00, "R2");
        // R3: logical right.
        send(1, 0, 64'h8001_0001_F00F_0010, 3, 8'h00, "R3");
        send(1, 1, 64'hFFFF_FFFF_1234_5678, 32, 8'h00, "R3");
        send(1, 2, 64'h8000_0000_0000_0100, 8, 8'h00, "R3");
        // R4: arithmetic right.
        send(2, 0, 64'h8000_7FFF_F0F0_0F0F, 4, 8'h00, "R4");
        send(2, 0, 64'h8000_7FFF_F0F0_0F0F, 200, 8'h00, "R4");
        send(2, 1, 64'h8000_0000_7FFF_FFFF, 31, 8'h00, "R4");
        send(2, 2, 64'h8000_0000_0000_0000, 64, 8'h00, "R4");
        send(2, 2, 64'h8000_0000_0000_0000, 12, 8'h00, "R4");
        // R5: rotate right.
        send(3, 0, 64'h1234_5678_9ABC_DEF0, 0, 8'h00, "R5");
        send(3, 0, 64'h0001_8000_00FF_1234, 5, 8'h00, "R5");
        send(3, 1, 64'h0000_000F_8000_0001, 36, 8'h00, "R5");
        send(3, 2, 64'h0123_4567_89AB_CDEF, 12, 8'h00, "R5");
        // R13: every amount bit counts.
        send(3, 0, 64'h0001_0002_0004_8000, 8'h11, 8'h00, "R13");
        send(0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 8'h41, 8'h00, "R13");
        send(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h80, 8'h00, "R13");
        // R6: code 3 is a 64-bit lane.
        send(1, 3, 64'hF000_0000_0000_0000, 4, 8'h00, "R6");
        send(3, 3, 64'h0000_0000_0000_0001, 1, 8'h00, "R6");
        // R7: permute, amount and lane code ignored.
        send(4, 1, 64'h4444_3333_2222_1111, 9, 8'hE4, "R7");
        send(4, 2, 64'h4444_3333_2222_1111, 77, 8'h1B, "R7");
        send(4, 0, 64'h4444_3333_2222_1111, 3, 8'hAA, "R7");
        // R8, R9, R10: flag layouts.
        send(0, 0, 64'h0000_8000_0001_7FFF, 0, 8'h00, "R8");
        send(1, 1, 64'h8000_0000_0000_0000, 0, 8'h00, "R9");
        send(1, 1, 64'h0000_0001_FFFF_0000, 16, 8'h00, "R9");
        send(1, 2, 64'h0000_0000_0000_0001, 1, 8'h00, "R10");
        send(0, 3, 64'h0000_0000_0000_0001, 63, 8'h00, "R10");
        // R11: permute flags in halfword layout.
        send(4, 2, 64'h0000_8000_0000_0001, 0, 8'h4E, "R11");
        // R12: unused codes.
        send(5, 0, 64'hFFFF_0000_8000_1234, 1, 8'h00, "R12");
        send(6, 1, 64'h0000_0000_0000_0000, 0, 8'h00, "R12");
        send(7, 2, 64'h8000_0000_0000_0000, 3, 8'hFF, "R12");

        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        check(exp_r.size() == 0, "R1", "results outstanding", 64'(exp_r.size()), 64'd0);
        check(out_valid == 1'b0, "R1", "out_valid idle", {63'd0, out_valid}, 64'd0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule